// File: doc/BRIEF.md
# Descriptor Ring and Chain DMA Walker

This block moves data between system memory and a card-side word FIFO under the control of 16-byte transfer descriptors that software prepares in memory. After a start pulse it fetches the descriptor at the programmed base address. If the descriptor is marked as owned by the engine, the block walks its data buffers one 32-bit word at a time. It then returns the descriptor to software by writing back its attribute word with the ownership bit cleared. Finally it either stops or moves on to the next descriptor.

Two layouts are supported and chosen by the `mode_dual` input. In chained mode each descriptor has one data buffer, and its fourth word holds the address of the next descriptor. In dual-buffer mode each descriptor has two data buffers, and the next descriptor lies at a fixed distance: 16 bytes plus a programmable number of padding words. If the engine finds a descriptor it does not own, it suspends. A poll-demand strobe makes it fetch that same descriptor again. Completion, unavailability and bus faults are collected in a sticky status register with an interrupt output.

Top module: `dma_desc_walker`

## Requirements
- R1: A descriptor is four 32-bit words at byte offsets 0, 4, 8 and 12. Word 0 is the attribute word, with owned-by-engine at bit 31, no-completion-interrupt at bit 0, end-of-ring at bit 1 and last-descriptor at bit 2. Word 1 is the size word, with the buffer-1 byte count in bits [12:0] and the buffer-2 byte count in bits [25:13]. Word 2 is the buffer-1 address. Word 3 is the buffer-2 address, or the next-descriptor address in chained mode.
- R2: In chained mode (`mode_dual`=0) only buffer 1 is transferred, whatever the buffer-2 count, and the next descriptor is fetched from the address held in word 3.
- R3: In dual-buffer mode (`mode_dual`=1) buffer 1 is transferred and then buffer 2. The next descriptor address is the current one plus 16 plus 4 times `skip_words`.
- R4: If the attribute word has bit 31 clear, status bits 1 (unavailable) and 4 (abnormal summary) are set. The engine then suspends and issues no memory request until `poll_demand` is pulsed, which fetches the same descriptor again.
- R5: `poll_demand` has no effect while the engine is not suspended.
- R6: After a descriptor's buffers are done, its attribute word is written back with bit 31 cleared and every other bit unchanged.
- R7: When the write-back of a descriptor with bit 0 clear is acknowledged, status bit 0 (transfer done) and bit 3 (normal summary) are set. A descriptor with bit 0 set leaves them untouched.
- R8: The walk stops after a descriptor with the last bit set. In dual-buffer mode it also stops after one with the end-of-ring bit set. In chained mode the end-of-ring bit is ignored.
- R9: An acknowledged memory access with `mem_err` high sets status bits 2 (bus fault) and 4 and halts the engine. The current descriptor is not written back, and only a new start leaves the halt.
- R10: A buffer with a byte count below 4 is skipped with no memory access. Byte counts are taken in whole words.
- R11: With `to_card`=1, words are read from memory at ascending addresses and offered on the tx stream in that order. With `to_card`=0, words taken from the rx stream are written to ascending memory addresses.
- R12: Writing ones on `status_clr` clears those status bits, with a set in the same cycle taking priority. `irq` is high while bit 3 or bit 4 is set.
- R13: A memory request keeps its address, direction and data until `mem_ack`, and every address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_dual | input | 1 | 1 selects the dual-buffer layout, 0 the chained layout |
| to_card | input | 1 | 1: memory to tx stream; 0: rx stream to memory |
| skip_words | input | SKIP_W | Padding words between dual-buffer descriptors |
| base_addr | input | AW | Address of the first descriptor |
| start | input | 1 | Begin a walk at base_addr (accepted when idle, halted or suspended) |
| poll_demand | input | 1 | Re-fetch the current descriptor when suspended |
| status_clr | input | 5 | Write-one-to-clear mask for status |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write request |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Completed request had a bus fault |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Word offered to the FIFO |
| tx_data | output | 32 | Offered word |
| tx_ready | input | 1 | FIFO accepts the word |
| rx_valid | input | 1 | FIFO has a word for memory |
| rx_data | input | 32 | Word from the FIFO |
| rx_ready | output | 1 | Engine takes the rx word |
| status | output | 5 | Sticky flags: done, unavailable, bus fault, normal, abnormal |
| irq | output | 1 | Summary interrupt |

## Verification
A chained two-descriptor walk runs with a nonzero buffer-2 count and the end-of-ring bit set on its first descriptor. It separates the next-pointer path from the skip-distance path and shows that chained mode ignores buffer 2 and the ring flag. A dual-buffer walk with padding words, ending on the ring flag, checks the skip arithmetic and the buffer order, and leaves an owned descriptor beyond the ring untouched. Further cases cover an empty first buffer whose address is a fault address, an unowned descriptor later handed over and polled, a poll while idle, and a fault in the middle of a buffer. Together they tell skipping apart from accessing, a suspend apart from a halt, and write-back apart from abandonment.

// File: rtl/desc_walk_pkg.sv
package desc_walk_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_BYTES = 16;
    localparam int SZ_W       = 13;
    localparam int LEFT_W     = SZ_W - 2;

    localparam int ATTR_OWN      = 31;
    localparam int ATTR_NOIRQ    = 0;
    localparam int ATTR_RING_END = 1;
    localparam int ATTR_LAST     = 2;

    localparam int ST_DONE    = 0;
    localparam int ST_UNAVAIL = 1;
    localparam int ST_BUSERR  = 2;
    localparam int ST_NORM    = 3;
    localparam int ST_ABN     = 4;
    localparam int ST_W       = 5;

    typedef enum logic [3:0] {
        S_IDLE, S_ATTR, S_SIZE, S_ADDR1, S_ADDR2,
        S_BUF_SEL, S_XFER, S_WBACK, S_NEXT, S_SUSP, S_HALT
    } walk_state_e;
endpackage

// File: rtl/desc_next_addr.sv
module desc_next_addr
    import desc_walk_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SKIP_W = 5
) (
    input  logic              mode_dual,
    input  logic [AW-1:0]     desc_addr,
    input  logic [AW-1:0]     link_addr,
    input  logic [SKIP_W-1:0] skip_words,
    output logic [AW-1:0]     next_addr
);
    localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);

    logic [AW-1:0] pad_bytes;

    always_comb begin
        pad_bytes = {{(AW-SKIP_W){1'b0}}, skip_words} << 2;
        if (mode_dual) begin
            next_addr = desc_addr + STRIDE + pad_bytes;
        end else begin
            next_addr = link_addr;
        end
    end
endmodule

// File: rtl/desc_status_reg.sv
module desc_status_reg
    import desc_walk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_done,
    input  logic            set_unavail,
    input  logic            set_buserr,
    input  logic [ST_W-1:0] clr,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    logic [ST_W-1:0] status_d, status_q, set_vec;

    always_comb begin
        set_vec = '0;
        set_vec[ST_DONE]    = set_done;
        set_vec[ST_NORM]    = set_done;
        set_vec[ST_UNAVAIL] = set_unavail;
        set_vec[ST_BUSERR]  = set_buserr;
        set_vec[ST_ABN]     = set_unavail | set_buserr;
        status_d = (status_q & ~clr) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status = status_q;
    assign irq    = status_q[ST_NORM] | status_q[ST_ABN];
endmodule

// File: rtl/dma_desc_walker.sv
module dma_desc_walker
    import desc_walk_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SKIP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_dual,
    input  logic              to_card,
    input  logic [SKIP_W-1:0] skip_words,
    input  logic [AW-1:0]     base_addr,
    input  logic              start,
    input  logic              poll_demand,
    input  logic [ST_W-1:0]   status_clr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    output logic              rx_ready,
    output logic [ST_W-1:0]   status,
    output logic              irq
);
    localparam logic [AW-1:0]     OFF_SIZE  = AW'(4);
    localparam logic [AW-1:0]     OFF_ADDR1 = AW'(8);
    localparam logic [AW-1:0]     OFF_ADDR2 = AW'(12);
    localparam logic [AW-1:0]     WORD_STEP = AW'(WORD_W / 8);
    localparam logic [WORD_W-1:0] OWN_MASK  = WORD_W'(1) << ATTR_OWN;

    typedef struct packed {
        walk_state_e       st;
        logic [AW-1:0]     desc;
        logic [AW-1:0]     a1;
        logic [AW-1:0]     a2;
        logic [AW-1:0]     ptr;
        logic [WORD_W-1:0] attr;
        logic [WORD_W-1:0] word;
        logic [SZ_W-1:0]   sz1;
        logic [SZ_W-1:0]   sz2;
        logic [LEFT_W-1:0] left;
        logic              buf2;
        logic              hold;
    } walk_regs_t;

    walk_regs_t        r_q, r_d;
    logic [AW-1:0]     next_addr;
    logic [SZ_W-1:0]   cur_sz;
    logic [LEFT_W-1:0] cur_words;
    logic              adv;
    logic              set_done, set_unavail, set_buserr;

    desc_next_addr #(.AW(AW), .SKIP_W(SKIP_W)) u_next (
        .mode_dual (mode_dual),
        .desc_addr (r_q.desc),
        .link_addr (r_q.a2),
        .skip_words(skip_words),
        .next_addr (next_addr)
    );

    desc_status_reg u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_done   (set_done),
        .set_unavail(set_unavail),
        .set_buserr (set_buserr),
        .clr        (status_clr),
        .status     (status),
        .irq        (irq)
    );

    always_comb begin
        r_d         = r_q;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = r_q.desc;
        mem_wdata   = r_q.word;
        tx_valid    = 1'b0;
        rx_ready    = 1'b0;
        adv         = 1'b0;
        set_done    = 1'b0;
        set_unavail = 1'b0;
        set_buserr  = 1'b0;
        cur_sz      = r_q.buf2 ? r_q.sz2 : r_q.sz1;
        cur_words   = LEFT_W'(cur_sz >> 2);

        unique case (r_q.st)
            S_IDLE, S_HALT: begin
                if (start) begin
                    r_d.desc = base_addr;
                    r_d.st   = S_ATTR;
                end
            end
            S_SUSP: begin
                if (start) begin
                    r_d.desc = base_addr;
                    r_d.st   = S_ATTR;
                end else if (poll_demand) begin
                    r_d.st = S_ATTR;
                end
            end
            S_ATTR: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    r_d.attr = mem_rdata;
                    if (!mem_rdata[ATTR_OWN]) begin
                        set_unavail = 1'b1;
                        r_d.st      = S_SUSP;
                    end else begin
                        r_d.st = S_SIZE;
                    end
                end
            end
            S_SIZE: begin
                mem_req  = 1'b1;
                mem_addr = r_q.desc + OFF_SIZE;
                if (mem_ack) begin
                    r_d.sz1 = mem_rdata[SZ_W-1:0];
                    r_d.sz2 = mem_rdata[2*SZ_W-1:SZ_W];
                    r_d.st  = S_ADDR1;
                end
            end
            S_ADDR1: begin
                mem_req  = 1'b1;
                mem_addr = r_q.desc + OFF_ADDR1;
                if (mem_ack) begin
                    r_d.a1 = mem_rdata[AW-1:0];
                    r_d.st = S_ADDR2;
                end
            end
            S_ADDR2: begin
                mem_req  = 1'b1;
                mem_addr = r_q.desc + OFF_ADDR2;
                if (mem_ack) begin
                    r_d.a2   = mem_rdata[AW-1:0];
                    r_d.buf2 = 1'b0;
                    r_d.st   = S_BUF_SEL;
                end
            end
            S_BUF_SEL: begin
                if (r_q.buf2 && !mode_dual) begin
                    r_d.st = S_WBACK;
                end else if (cur_words == '0) begin
                    if (r_q.buf2) begin
                        r_d.st = S_WBACK;
                    end else begin
                        r_d.buf2 = 1'b1;
                    end
                end else begin
                    r_d.ptr  = r_q.buf2 ? r_q.a2 : r_q.a1;
                    r_d.left = cur_words;
                    r_d.hold = 1'b0;
                    r_d.st   = S_XFER;
                end
            end
            S_XFER: begin
                mem_addr = r_q.ptr;
                if (to_card) begin
                    if (!r_q.hold) begin
                        mem_req = 1'b1;
                        if (mem_ack) begin
                            r_d.word = mem_rdata;
                            r_d.hold = 1'b1;
                        end
                    end else begin
                        tx_valid = 1'b1;
                        adv      = tx_ready;
                    end
                end else begin
                    if (!r_q.hold) begin
                        rx_ready = 1'b1;
                        if (rx_valid) begin
                            r_d.word = rx_data;
                            r_d.hold = 1'b1;
                        end
                    end else begin
                        mem_req = 1'b1;
                        mem_we  = 1'b1;
                        adv     = mem_ack;
                    end
                end
                if (adv) begin
                    r_d.hold = 1'b0;
                    r_d.ptr  = r_q.ptr + WORD_STEP;
                    r_d.left = r_q.left - 1'b1;
                    if (r_q.left == LEFT_W'(1)) begin
                        if (r_q.buf2) begin
                            r_d.st = S_WBACK;
                        end else begin
                            r_d.buf2 = 1'b1;
                            r_d.st   = S_BUF_SEL;
                        end
                    end
                end
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = r_q.attr & ~OWN_MASK;
                if (mem_ack) begin
                    set_done = !r_q.attr[ATTR_NOIRQ];
                    r_d.st   = S_NEXT;
                end
            end
            S_NEXT: begin
                if (r_q.attr[ATTR_LAST] || (mode_dual && r_q.attr[ATTR_RING_END])) begin
                    r_d.st = S_IDLE;
                end else begin
                    r_d.desc = next_addr;
                    r_d.st   = S_ATTR;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        if (mem_req && mem_ack && mem_err) begin
            r_d         = r_q;
            r_d.st      = S_HALT;
            set_buserr  = 1'b1;
            set_done    = 1'b0;
            set_unavail = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_data = r_q.word;
endmodule

// File: rtl/desc_walk_checker.sv
module desc_walk_checker
    import desc_walk_pkg::*;
#(
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              mem_err,
    input logic              tx_valid,
    input logic [WORD_W-1:0] tx_data,
    input logic              tx_ready,
    input logic              rx_ready,
    input logic [ST_W-1:0]   status
);
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    a_r13_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    a_r11_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && rx_ready));

    a_r9_buserr_flags: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_err |=> status[ST_BUSERR] && status[ST_ABN] && !mem_req);

    a_r4_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_UNAVAIL]) |-> !mem_req);

    a_r7_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_DONE]) |-> $past(mem_req && mem_we && mem_ack && !mem_err));
endmodule

bind dma_desc_walker desc_walk_checker #(.AW(AW)) u_walk_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .mem_err  (mem_err),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .rx_ready (rx_ready),
    .status   (status)
);

// File: tb/dma_desc_walker_test.sv
module dma_desc_walker_test;
    localparam logic [31:0] OWN   = 32'h8000_0000;
    localparam logic [31:0] NOIRQ = 32'h1;
    localparam logic [31:0] RING  = 32'h2;
    localparam logic [31:0] LAST  = 32'h4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_dual = 1'b0;
    logic        to_card = 1'b1;
    logic [4:0]  skip_words = '0;
    logic [31:0] base_addr = '0;
    logic        start = 1'b0;
    logic        poll_demand = 1'b0;
    logic [4:0]  status_clr = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack, mem_err;
    logic [31:0] mem_rdata;
    logic        tx_valid;
    logic [31:0] tx_data;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b1;
    logic [31:0] rx_data;
    logic        rx_ready;
    logic [4:0]  status;
    logic        irq;

    logic [31:0] mem [0:1023];
    logic [31:0] txlog [0:15];
    int          txn, reqcnt, misalign;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic        poke_en = 1'b0;
    logic [31:0] poke_a = '0, poke_d = '0;
    int          total = 0, bad = 0;

    always #10 clk = ~clk;

    dma_desc_walker uut (
        .clk(clk), .rst_n(rst_n), .mode_dual(mode_dual), .to_card(to_card),
        .skip_words(skip_words), .base_addr(base_addr), .start(start),
        .poll_demand(poll_demand), .status_clr(status_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .status(status), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack  <= 1'b0;
            mem_err  <= 1'b0;
            txn      <= 0;
            reqcnt   <= 0;
            misalign <= 0;
            rx_data  <= 32'hA000_0000;
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
            if (poke_en) mem[poke_a[11:2]] <= poke_d;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                reqcnt  <= reqcnt + 1;
                if (mem_addr[1:0] != 2'b00) misalign <= misalign + 1;
                if (mem_addr == err_addr) begin
                    mem_err <= 1'b1;
                end else begin
                    if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
                    mem_rdata <= mem[mem_addr[11:2]];
                end
            end
            if (tx_valid && tx_ready) begin
                txlog[txn[3:0]] <= tx_data;
                txn <= txn + 1;
            end
            if (rx_valid && rx_ready) rx_data <= rx_data + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_a = a; poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] attr,
                            input logic [12:0] b1, input logic [12:0] b2,
                            input logic [31:0] a1, input logic [31:0] a2);
        poke(at, attr);
        poke(at + 4, {6'd0, b2, b1});
        poke(at + 8, a1);
        poke(at + 12, a2);
    endtask

    task automatic clear_all();
        @(negedge clk);
        status_clr = 5'h1F;
        @(negedge clk);
        status_clr = 5'h00;
    endtask

    task automatic kick(input logic [31:0] addr, input int cycles);
        @(negedge clk);
        base_addr = addr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R12 reset status", 32'(status), 32'h0);
        chk("R12 reset irq", 32'(irq), 32'h0);
        chk("R13 reset no request", 32'(mem_req), 32'h0);
        chk("R11 reset tx idle", 32'(tx_valid), 32'h0);
    endtask

    task automatic t_chained();
        int t0;
        mode_dual = 1'b0; to_card = 1'b1;
        put_desc(32'h100, OWN | NOIRQ | RING, 13'd8, 13'd12, 32'h400, 32'h140);
        put_desc(32'h140, OWN | LAST, 13'd4, 13'd0, 32'h500, 32'h0);
        poke(32'h400, 32'h11); poke(32'h404, 32'h22); poke(32'h500, 32'h33);
        clear_all();
        t0 = txn;
        kick(32'h100, 150);
        chk("R2 chained word count", 32'(txn - t0), 32'd3);
        chk("R11 first word", txlog[t0[3:0]], 32'h11);
        chk("R11 second word", txlog[4'(t0 + 1)], 32'h22);
        chk("R2 next-pointer word", txlog[4'(t0 + 2)], 32'h33);
        chk("R6 writeback keeps bits", mem[32'h100 >> 2], NOIRQ | RING);
        chk("R6 writeback last desc", mem[32'h140 >> 2], LAST);
        chk("R7 done from last desc", 32'(status), 32'h09);
        chk("R12 irq on normal", 32'(irq), 32'h1);
    endtask

    task automatic t_dual();
        logic [31:0] rx0;
        int t0;
        mode_dual = 1'b1; to_card = 1'b0; skip_words = 5'd2;
        put_desc(32'h200, OWN | NOIRQ, 13'd8, 13'd4, 32'h600, 32'h700);
        put_desc(32'h218, OWN | RING, 13'd4, 13'd0, 32'h800, 32'h0);
        put_desc(32'h230, OWN | LAST, 13'd4, 13'd0, 32'h900, 32'h0);
        poke(32'h704, 32'hDEAD);
        clear_all();
        @(negedge clk);
        rx0 = rx_data;
        t0 = txn;
        kick(32'h200, 150);
        chk("R11 rx word 0", mem[32'h600 >> 2], rx0);
        chk("R11 rx word 1", mem[32'h604 >> 2], rx0 + 1);
        chk("R3 buffer 2 after buffer 1", mem[32'h700 >> 2], rx0 + 2);
        chk("R3 buffer 2 length", mem[32'h704 >> 2], 32'hDEAD);
        chk("R3 skip distance", mem[32'h800 >> 2], rx0 + 3);
        chk("R8 ring end stops", mem[32'h230 >> 2], OWN | LAST);
        chk("R11 no tx when writing", 32'(txn - t0), 32'd0);
        chk("R7 done with dual", 32'(status), 32'h09);
    endtask

    task automatic t_zero();
        int t0;
        mode_dual = 1'b1; to_card = 1'b1;
        put_desc(32'h300, OWN | LAST | NOIRQ, 13'd0, 13'd4, 32'h980, 32'h9C0);
        poke(32'h980, 32'h77); poke(32'h9C0, 32'h99);
        err_addr = 32'h980;
        clear_all();
        t0 = txn;
        kick(32'h300, 80);
        chk("R10 only buffer 2 moved", 32'(txn - t0), 32'd1);
        chk("R10 buffer 2 word", txlog[t0[3:0]], 32'h99);
        chk("R10 no access to empty buffer", 32'(status), 32'h00);
        chk("R7 suppressed done, desc returned", mem[32'h300 >> 2], LAST | NOIRQ);
        err_addr = 32'hFFFF_FFFF;
    endtask

    task automatic t_unavail();
        int t0, r0;
        mode_dual = 1'b0; to_card = 1'b1;
        put_desc(32'h380, LAST, 13'd4, 13'd0, 32'hA00, 32'h0);
        poke(32'hA00, 32'h55);
        clear_all();
        t0 = txn;
        kick(32'h380, 20);
        chk("R4 unavailable flags", 32'(status), 32'h12);
        chk("R4 irq on abnormal", 32'(irq), 32'h1);
        r0 = reqcnt;
        repeat (20) @(negedge clk);
        chk("R4 suspended is quiet", 32'(reqcnt - r0), 32'd0);
        chk("R4 no data while suspended", 32'(txn - t0), 32'd0);
        poke(32'h380, OWN | LAST);
        @(negedge clk);
        poll_demand = 1'b1;
        @(negedge clk);
        poll_demand = 1'b0;
        repeat (60) @(negedge clk);
        chk("R4 poll refetch data", txlog[t0[3:0]], 32'h55);
        chk("R6 poll writeback", mem[32'h380 >> 2], LAST);
        chk("R4 done after poll", 32'(status), 32'h1B);
    endtask

    task automatic t_idle_poll();
        int t0, r0;
        t0 = txn; r0 = reqcnt;
        @(negedge clk);
        poll_demand = 1'b1;
        @(negedge clk);
        poll_demand = 1'b0;
        repeat (30) @(negedge clk);
        chk("R5 idle poll no request", 32'(reqcnt - r0), 32'd0);
        chk("R5 idle poll no data", 32'(txn - t0), 32'd0);
    endtask

    task automatic t_buserr();
        int t0, r0;
        mode_dual = 1'b0; to_card = 1'b1;
        put_desc(32'h3C0, OWN | LAST, 13'd8, 13'd0, 32'hB00, 32'h0);
        poke(32'hB00, 32'h66);
        err_addr = 32'hB04;
        clear_all();
        t0 = txn;
        kick(32'h3C0, 80);
        chk("R9 fault flags", 32'(status), 32'h14);
        chk("R9 word before fault", 32'(txn - t0), 32'd1);
        chk("R9 descriptor kept owned", mem[32'h3C0 >> 2], OWN | LAST);
        r0 = reqcnt;
        repeat (20) @(negedge clk);
        chk("R9 halted", 32'(reqcnt - r0), 32'd0);
        err_addr = 32'hFFFF_FFFF;
    endtask

    task automatic t_clear();
        @(negedge clk);
        status_clr = 5'h04;
        @(negedge clk);
        status_clr = 5'h00;
        chk("R12 partial clear", 32'(status), 32'h10);
        chk("R12 irq held by abnormal", 32'(irq), 32'h1);
        status_clr = 5'h10;
        @(negedge clk);
        status_clr = 5'h00;
        chk("R12 full clear", 32'(status), 32'h00);
        chk("R12 irq low", 32'(irq), 32'h0);
        chk("R13 aligned requests", 32'(misalign), 32'd0);
        chk("R1 layout total checks", 32'(reqcnt > 0), 32'h1);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_chained();
        t_dual();
        t_zero();
        t_unavail();
        t_idle_poll();
        t_buserr();
        t_clear();
        finish_run();
    end
endmodule